// File: doc/BRIEF.md
# Time-Interval Converter Sequencer

This block sits above a group of delay-line timing channels and decides what they do. It is a Moore state machine with four states: start-up, idle, calibrate and measure. A one-byte control/status register selects the state. Three command lines go to every channel at once. One holds the channels in restore during start-up, one enables continuous measurement, and one marks calibration.

In calibration the sequencer handles the channels one after another, in ascending order. For each channel it samples the number of taps that channel's line covered in one clock period. A bit-serial restoring divider then turns that count into the time of one step: the clock period in picoseconds divided by the tap count. The sequencer next writes the step time multiplied by each possible tap code into that channel's lookup table. When the last channel is done, it clears the calibration request bit and returns to idle.

Top module: `tdc_ctrl`

## Requirements
- R1: While reset is held, the state is start-up (code 0), all control bits read as zero, restore is high and enable, calibrate and table write are low.
- R2: Start-up lasts exactly one cycle and is always followed by idle (code 1). On leaving start-up the run, calibrate and force bits are cleared, unless a register write lands in the same cycle.
- R3: The commands depend only on the state: restore is high only in start-up, enable only in measure (code 3), and calibrate only in calibrate (code 2).
- R4: In idle, control bit 0 set moves the state to measure. In measure, bit 0 clear moves it back to idle.
- R5: In idle, control bit 1 set moves the state to calibrate. Bit 1 takes priority over bit 0.
- R6: Control bit 4 set moves any state other than start-up into start-up on the next clock. This also aborts a calibration in progress.
- R7: For each channel the step time is floor(PERIOD_PS / taps), computed by a restoring divider that finishes before the first table write. A tap count of zero gives all ones in the quotient width.
- R8: Table writes proceed channel by channel in ascending order. For each channel, addresses run 0 to 2^TAP_W-1 on consecutive cycles, and each data word is the step time multiplied by the address.
- R9: After the last write of the last channel, bit 1 reads back as zero and the state is idle.
- R10: A register read returns run in bit 0, calibrate in bit 1, force in bit 4 and the state code in bits 7:6. Bits 2, 3 and 5 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Control/status read value |
| taps | input | NCH*TAP_W | Per-channel tap count reached in one clock period |
| ch_enable | output | 1 | Measure command to all channels |
| ch_restore | output | 1 | Restore command to all channels |
| ch_calib | output | 1 | Calibrate command to all channels |
| tbl_we | output | 1 | Lookup table write strobe |
| tbl_sel | output | CW | Channel whose table is written |
| tbl_addr | output | TAP_W | Table address (tap code) |
| tbl_data | output | DW | Time value for that code |

## Verification
The assertions assume two things about the inputs. First, the tap counts stay steady while a channel's division runs. Second, nothing writes bit 4 while table writes are being checked for consecutive addresses. The stimulus changes tap counts only when the state is idle, and it sets bit 4 only in the force and abort tests. The bench sweeps every tap code from 0 to 15 across both channels, so the zero divisor and the largest divisor are both covered.

// File: rtl/tdc_ctrl.sv
module tdc_ctrl #(
  parameter int NCH = 2,
  parameter int TAP_W = 4,
  parameter int PERIOD_PS = 10000,
  localparam int QW = $clog2(PERIOD_PS + 1),
  localparam int DW = QW + TAP_W,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic [NCH*TAP_W-1:0] taps,
  output logic                 ch_enable,
  output logic                 ch_restore,
  output logic                 ch_calib,
  output logic                 tbl_we,
  output logic [CW-1:0]        tbl_sel,
  output logic [TAP_W-1:0]     tbl_addr,
  output logic [DW-1:0]        tbl_data
);
  localparam int DCW = (QW > 1) ? $clog2(QW) : 1;
  localparam logic [1:0] S_INIT = 2'd0, S_IDLE = 2'd1, S_CAL = 2'd2, S_RUN = 2'd3;
  localparam logic [1:0] P_LOAD = 2'd0, P_DIV = 2'd1, P_WR = 2'd2;

  logic [1:0] state, phase;
  logic run_b, cal_b, init_b;
  logic [CW-1:0] ch_idx;
  logic [DCW-1:0] dcnt;
  logic [TAP_W:0] rem, sh, diff;
  logic [QW-1:0] quo;
  logic [TAP_W-1:0] dvs, addr;
  logic geq, last_ch, last_addr, cal_done;

  assign sh        = {rem[TAP_W-1:0], quo[QW-1]};
  assign diff      = sh - {1'b0, dvs};
  assign geq       = sh >= {1'b0, dvs};
  assign last_ch   = ch_idx == CW'(NCH - 1);
  assign last_addr = &addr;
  assign cal_done  = state == S_CAL && phase == P_WR && last_addr && last_ch;

  assign ch_enable  = state == S_RUN;
  assign ch_restore = state == S_INIT;
  assign ch_calib   = state == S_CAL;
  assign tbl_we     = state == S_CAL && phase == P_WR;
  assign tbl_sel    = ch_idx;
  assign tbl_addr   = addr;
  assign tbl_data   = DW'(quo) * DW'(addr);
  assign reg_rdata  = {state, 1'b0, init_b, 2'b00, cal_b, run_b};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_b <= 1'b0; cal_b <= 1'b0; init_b <= 1'b0;
    end else begin
      if (state == S_INIT) begin
        run_b <= 1'b0; cal_b <= 1'b0; init_b <= 1'b0;
      end else if (cal_done) cal_b <= 1'b0;
      if (reg_wr) begin
        run_b <= reg_wdata[0]; cal_b <= reg_wdata[1]; init_b <= reg_wdata[4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_INIT;
    else if (state == S_INIT) state <= S_IDLE;
    else if (init_b) state <= S_INIT;
    else begin
      case (state)
        S_IDLE: if (cal_b) state <= S_CAL; else if (run_b) state <= S_RUN;
        S_RUN:  if (!run_b) state <= S_IDLE;
        S_CAL:  if (cal_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || state != S_CAL) begin
      phase <= P_LOAD; ch_idx <= '0; dcnt <= '0; addr <= '0;
      rem <= '0; quo <= '0; dvs <= '0;
    end else begin
      case (phase)
        P_LOAD: begin
          rem <= '0;
          quo <= QW'(PERIOD_PS);
          dvs <= taps[int'(ch_idx)*TAP_W +: TAP_W];
          dcnt <= '0;
          phase <= P_DIV;
        end
        P_DIV: begin
          rem <= geq ? diff : sh;
          quo <= {quo[QW-2:0], geq};
          dcnt <= dcnt + 1'b1;
          if (dcnt == DCW'(QW - 1)) begin
            phase <= P_WR; addr <= '0;
          end
        end
        default: begin
          addr <= addr + 1'b1;
          if (last_addr) begin
            ch_idx <= ch_idx + 1'b1; phase <= P_LOAD;
          end
        end
      endcase
    end
  end

  assert_init_leaves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_INIT |=> state == S_IDLE);
  assert_force_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_b && state != S_INIT) |=> state == S_INIT);
  assert_run_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_enable) |-> $past(run_b));
  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && !init_b && !last_addr) |=> (tbl_we && tbl_addr == $past(tbl_addr) + 1'b1));
  assert_div_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbl_we) |-> $past(phase) == P_DIV);
  assert_cal_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && $past(state) == S_CAL && !$past(reg_wr)) |-> !cal_b);
endmodule

// File: tb/tb_tdc_ctrl.sv
module tb_tdc_ctrl;
  localparam int NCH = 2, TAP_W = 4, PERIOD_PS = 10000;
  localparam int QW = $clog2(PERIOD_PS + 1), DW = QW + TAP_W;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [NCH*TAP_W-1:0] taps = '0;
  logic ch_enable, ch_restore, ch_calib, tbl_we;
  logic [0:0] tbl_sel;
  logic [TAP_W-1:0] tbl_addr;
  logic [DW-1:0] tbl_data;

  tdc_ctrl #(.NCH(NCH), .TAP_W(TAP_W), .PERIOD_PS(PERIOD_PS)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .taps(taps), .ch_enable(ch_enable),
    .ch_restore(ch_restore), .ch_calib(ch_calib), .tbl_we(tbl_we),
    .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_data(tbl_data));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int exp_n = 0;
  bit mon_on = 1'b0;
  int tap_v [NCH];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint step_of(input int t);
    return (t == 0) ? ((64'd1 << QW) - 1) : longint'(PERIOD_PS / t);
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (mon_on && tbl_we) begin
      automatic int ch = exp_n / 16, ad = exp_n % 16;
      chk(tbl_sel == ch[0:0] && tbl_addr == TAP_W'(ad), "R8 order",
          {tbl_sel, tbl_addr}, {ch[0:0], ad[3:0]});
      chk(tbl_data == DW'(step_of(tap_v[ch] ) * ad), "R7 data",
          tbl_data, step_of(tap_v[ch]) * ad);
      exp_n++;
    end
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic run_cal(input int t0, input int t1);
    tap_v[0] = t0; tap_v[1] = t1;
    taps = {TAP_W'(t1), TAP_W'(t0)};
    exp_n = 0; mon_on = 1'b1;
    wr(8'h02);
    @(negedge clk);
    chk(reg_rdata[7:6] == 2'd2 && ch_calib && !ch_enable, "R5 cal entry", reg_rdata, 8'h82);
    for (int k = 0; k < 200 && reg_rdata[7:6] == 2'd2; k++) @(negedge clk);
    mon_on = 1'b0;
    chk(exp_n == 32, "R8 write count", exp_n, 32);
    chk(reg_rdata == 8'h40, "R9 cal done", reg_rdata, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(reg_rdata == 8'h00, "R1 csr", reg_rdata, 0);
    chk(ch_restore && !ch_enable && !ch_calib && !tbl_we, "R1 cmds",
        {ch_restore, ch_enable, ch_calib, tbl_we}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_rdata == 8'h40 && !ch_restore, "R2 idle", reg_rdata, 8'h40);

    wr(8'h01);
    @(negedge clk);
    chk(reg_rdata == 8'hC1 && ch_enable && !ch_restore, "R4 run R3", reg_rdata, 8'hC1);
    wr(8'h2C);
    chk(reg_rdata == 8'hC0, "R10 spare bits", reg_rdata, 8'hC0);
    @(negedge clk);
    chk(reg_rdata == 8'h40 && !ch_enable, "R4 back idle", reg_rdata, 8'h40);

    for (int i = 0; i < 16; i++) run_cal(i, 15 - i);

    wr(8'h03);
    @(negedge clk);
    chk(reg_rdata[7:6] == 2'd2, "R5 priority", reg_rdata, 8'h83);
    for (int k = 0; k < 200 && reg_rdata[7:6] == 2'd2; k++) @(negedge clk);
    chk(reg_rdata == 8'h41, "R9 keep run", reg_rdata, 8'h41);
    @(negedge clk);
    chk(reg_rdata == 8'hC1, "R4 run after cal", reg_rdata, 8'hC1);

    wr(8'h11);
    @(negedge clk);
    chk(reg_rdata == 8'h11 && ch_restore, "R6 force", reg_rdata, 8'h11);
    @(negedge clk);
    chk(reg_rdata == 8'h40, "R2 cleared", reg_rdata, 8'h40);

    wr(8'h02);
    repeat (20) @(negedge clk);
    wr(8'h12);
    @(negedge clk);
    chk(reg_rdata[7:6] == 2'd0 && !ch_calib, "R6 abort", reg_rdata, 8'h12);
    @(negedge clk);
    chk(reg_rdata == 8'h40, "R2 after abort", reg_rdata, 8'h40);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule